// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This peripheral holds a parameterised number of independent down-counting channels, 32 bits wide by default, behind a plain word-addressed register port made of a write strobe, an address, write data and combinational read data. Each channel owns a control word, an interval word and a read-only live count. A channel counts on its own prescaled tick and runs either periodically, reloading from its interval each time it expires, or once, after which hardware switches it off.

Every expiry sets a sticky per-channel pending bit, which software clears by writing a one to it. One interrupt line is the OR of the pending bits that are also enabled. Turning a channel off is not instant. The channel keeps counting for a short, bounded number of ticks after the write, so software has to wait that long before it reprograms the channel. Software that wants a rising time base reads the count and inverts it.

Top module: `mtimer_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Addresses: interrupt enable at 0x00 and pending status at 0x04, with bit n belonging to channel n. Channel n has its control word at 0x10+0x10*n, its interval at 0x14+0x10*n and its count at 0x18+0x10*n. Unmapped addresses read zero. Control bits: 0 run-enable, 1 reload request, 3:2 clock-source (stored and read back only), 6:4 prescale exponent P, 7 one-shot (1) or periodic (0). Control and interval writes read back from the next cycle.
- R3: A reload request copies the interval into the count on the channel's next tick, whether or not the channel runs. The bit reads 1 until that tick and 0 afterwards. That tick does not decrement.
- R4: With exponent P, the channel ticks every 2^P clock cycles. The first tick falls 2^P cycles after the control write. The count drops by one per tick only while the channel runs.
- R5: A running tick that finds the count at 1 or 0 is an expiry. It sets the channel's status bit, and in periodic mode it loads the interval. An all-ones interval gives a full-range free-running counter.
- R6: In one-shot mode an expiry leaves the count at 0 and clears the run-enable bit, which then reads back 0. The count stays at 0.
- R7: A write that clears run-enable still lets that cycle's tick count. After it, the count changes on at most two further ticks and then holds.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it as it is. An expiry in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when some channel has both its status bit and its enable bit set. Status bits are set even when their enable bit is 0.
- R10: Writes to a count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Most internal faults here show up within a handful of ticks as a wrong count or as a status bit set one tick early or late. A stale reload flag makes the control word read back with bit 1 still set and skips a decrement. A prescaler mask that is off by one moves the first tick of a divided channel by 2^P cycles. A stop sequence that does not drain, or drains too long, leaves the count of a stopped channel off by one or two. One-shot and write-one-to-clear faults leave the status word or `irq_o` at the wrong level on the very next read.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  localparam int unsigned PRE_W = 3;
  localparam int unsigned SRC_W = 2;

  // Control word, most significant field first
  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] pre;
    logic [SRC_W-1:0] src;
    logic             reload;
    logic             en;
  } ctrl_t;

  localparam int unsigned CTRL_W    = $bits(ctrl_t);
  localparam int unsigned REG_IEN   = 'h00;
  localparam int unsigned REG_IST   = 'h04;
  localparam int unsigned CH_BASE   = 'h10;
  localparam int unsigned CH_STRIDE = 'h10;
  localparam int unsigned OFF_CTRL  = 'h0;
  localparam int unsigned OFF_IVAL  = 'h4;
  localparam int unsigned OFF_CNT   = 'h8;

endpackage

// File: rtl/mtimer_chan.sv
module mtimer_chan
  import mtimer_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             ival_we,
  input  logic [CNT_W-1:0] wdata,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] ival_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  localparam int unsigned      DIV_W    = (1 << PRE_W) - 1;
  localparam int unsigned      DRN_W    = $clog2(SYNC_TICKS + 1);
  localparam logic [PRE_W-1:0] PRE_TOP  = PRE_W'(DIV_W);
  localparam logic [DIV_W-1:0] DIV_ONES = '1;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] ival_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] pre_q, pre_d;
  logic [DRN_W-1:0] drain_q, drain_d;
  logic [DIV_W-1:0] mask;
  logic             tick;
  logic             run;

  assign mask     = DIV_ONES >> (PRE_TOP - ctrl_q.pre);
  assign tick     = ((pre_q & mask) == mask);
  assign run      = ctrl_q.en | (drain_q != '0);
  assign expire_o = tick & ~ctrl_q.reload & run & (cnt_q <= CNT_W'(1));

  always_comb begin
    ctrl_d  = ctrl_q;
    cnt_d   = cnt_q;
    pre_d   = pre_q + DIV_W'(1);
    drain_d = drain_q;
    if (tick && !ctrl_q.en && drain_q != '0) begin
      drain_d = drain_q - DRN_W'(1);
    end
    if (tick) begin
      if (ctrl_q.reload) begin
        cnt_d         = ival_q;
        ctrl_d.reload = 1'b0;
      end else if (run) begin
        if (cnt_q <= CNT_W'(1)) begin
          if (ctrl_q.oneshot) begin
            cnt_d     = '0;
            ctrl_d.en = 1'b0;
            drain_d   = '0;
          end else begin
            cnt_d = ival_q;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
    if (ctrl_we) begin
      ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
      pre_d  = '0;
      if (wdata[0]) begin
        drain_d = '0;
      end else if (ctrl_q.en) begin
        drain_d = DRN_W'(SYNC_TICKS);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ival_q  <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
      drain_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
      drain_q <= drain_d;
      if (ival_we) begin
        ival_q <= wdata;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign ival_o = ival_q;
  assign cnt_o  = cnt_q;

  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.reload && tick && !ctrl_we) |=> (!ctrl_q.reload && cnt_q == $past(ival_q))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !ctrl_q.reload && cnt_q > CNT_W'(1) && !ctrl_we) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && ctrl_q.oneshot && !ctrl_we) |=> (!ctrl_q.en && cnt_q == '0)); // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctrl_q.reload && !ctrl_we) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/mtimer_irq.sv
module mtimer_irq #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_we,
  input  logic              ist_we,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] set,
  output logic [NUM_CH-1:0] ien_o,
  output logic [NUM_CH-1:0] ist_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] ist_q, ist_d;
  logic [NUM_CH-1:0] clr;

  assign clr   = ist_we ? wdata : '0;
  assign ist_d = (ist_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      ist_q <= ist_d;
      if (ien_we) begin
        ien_q <= wdata;
      end
    end
  end

  assign ien_o = ien_q;
  assign ist_o = ist_q;
  assign irq_o = |(ist_q & ien_q);

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ist_we |=> ((ist_q & $past(wdata) & ~$past(set)) == '0)); // R8
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ist_we |=> (((ist_q ^ $past(ist_q)) & ~$past(wdata) & ~$past(set)) == '0)); // R8
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((ist_q & $past(set)) == $past(set))); // R9

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(REG_IEN);
  localparam logic [ADDR_W-1:0] A_IST = ADDR_W'(REG_IST);

  ctrl_t             ctrl_a [NUM_CH];
  logic [CNT_W-1:0]  ival_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] ien, ist;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_IVAL = ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_IVAL);
    logic ctrl_we, ival_we;
    assign ctrl_we = bus_we && (bus_addr == A_CTRL);
    assign ival_we = bus_we && (bus_addr == A_IVAL);

    mtimer_chan #(
      .CNT_W      (CNT_W),
      .SYNC_TICKS (SYNC_TICKS)
    ) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (ctrl_we),
      .ival_we  (ival_we),
      .wdata    (bus_wdata),
      .ctrl_o   (ctrl_a[c]),
      .ival_o   (ival_a[c]),
      .cnt_o    (cnt_a[c]),
      .expire_o (expire[c])
    );
  end

  mtimer_irq #(
    .NUM_CH (NUM_CH)
  ) irq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ien_we (bus_we && (bus_addr == A_IEN)),
    .ist_we (bus_we && (bus_addr == A_IST)),
    .wdata  (bus_wdata[NUM_CH-1:0]),
    .set    (expire),
    .ien_o  (ien),
    .ist_o  (ist),
    .irq_o  (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_IEN) bus_rdata[NUM_CH-1:0] = ien;
    if (bus_addr == A_IST) bus_rdata[NUM_CH-1:0] = ist;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CTRL))
        bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_a[c]};
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_IVAL))
        bus_rdata = ival_a[c];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFF_CNT))
        bus_rdata = cnt_a[c];
    end
  end

endmodule

// File: tb/mtimer_top_tb.sv
module mtimer_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 18;

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  gap;
    logic [3:0]  req;
  } vec_t;

  // Channel 0, prescale 0, periodic, interval 5
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h14, 32'd5,    4'd0, 4'd2},  // R2 interval write
    '{1'b0, 8'h00, 32'd1,    4'd0, 4'd2},  // R2 enable irq ch0
    '{1'b0, 8'h10, 32'h03,   4'd1, 4'd3},  // R3 run + reload
    '{1'b1, 8'h18, 32'd5,    4'd0, 4'd3},  // R3 count loaded
    '{1'b1, 8'h10, 32'h01,   4'd4, 4'd3},  // R3 reload bit reads 0
    '{1'b1, 8'h18, 32'd1,    4'd0, 4'd4},  // R4 one per tick
    '{1'b1, 8'h04, 32'd0,    4'd1, 4'd5},  // R5 not yet expired
    '{1'b1, 8'h18, 32'd5,    4'd0, 4'd5},  // R5 periodic reload
    '{1'b1, 8'h04, 32'd1,    4'd0, 4'd5},  // R5 status set
    '{1'b0, 8'h04, 32'd0,    4'd0, 4'd8},  // R8 write zero
    '{1'b1, 8'h04, 32'd1,    4'd0, 4'd8},  // R8 still pending
    '{1'b0, 8'h04, 32'd1,    4'd0, 4'd8},  // R8 write one
    '{1'b1, 8'h04, 32'd0,    4'd0, 4'd8},  // R8 cleared
    '{1'b1, 8'h18, 32'd3,    4'd0, 4'd4},  // R4 keeps counting
    '{1'b0, 8'h18, 32'hAB,   4'd0, 4'd10}, // R10 write count
    '{1'b1, 8'h18, 32'd2,    4'd0, 4'd10}, // R10 write ignored
    '{1'b1, 8'h14, 32'd5,    4'd0, 4'd2},  // R2 interval readback
    '{1'b1, 8'h08, 32'd0,    4'd0, 4'd2}   // R2 unmapped
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtimer_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 'h30; a += 4) expect_rd("R1 reset read", 8'(a), 32'd0);
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].rd) expect_rd($sformatf("R%0d table %0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
      else wr(VECS[i].addr, VECS[i].data);
      idle(int'(VECS[i].gap));
    end

    // R7 stop drains: tick of the write cycle plus two more
    wr(8'h10, 32'h00);
    idle(3);
    expect_rd("R7 count after stop", 8'h18, 32'd4);
    expect_rd("R7 ctrl after stop", 8'h10, 32'd0);
    expect_rd("R5 expiry during drain", 8'h04, 32'd1);
    check("R9 irq enabled pending", {31'd0, irq_o}, 32'd1);
    idle(4);
    expect_rd("R7 count holds", 8'h18, 32'd4);
    wr(8'h04, 32'h3);
    check("R9 irq after clear", {31'd0, irq_o}, 32'd0);

    // R6 one-shot on channel 1, its irq disabled
    wr(8'h24, 32'd3);
    wr(8'h20, 32'h83);
    idle(3);
    expect_rd("R6 count before expiry", 8'h28, 32'd1);
    expect_rd("R6 ctrl running", 8'h20, 32'h81);
    idle(1);
    expect_rd("R6 count at zero", 8'h28, 32'd0);
    expect_rd("R6 enable cleared", 8'h20, 32'h80);
    expect_rd("R9 status set while masked", 8'h04, 32'd2);
    check("R9 irq masked", {31'd0, irq_o}, 32'd0);
    idle(5);
    expect_rd("R6 count stays zero", 8'h28, 32'd0);
    wr(8'h00, 32'd2);
    check("R9 irq unmasked", {31'd0, irq_o}, 32'd1);
    wr(8'h04, 32'd2);
    check("R8 irq after w1c", {31'd0, irq_o}, 32'd0);
    expect_rd("R8 status cleared", 8'h04, 32'd0);

    // R4 prescale exponent 2 on channel 1
    wr(8'h24, 32'd10);
    wr(8'h20, 32'h23);
    idle(3);
    expect_rd("R4 no tick before 4 cycles", 8'h28, 32'd0);
    idle(1);
    expect_rd("R4 first tick reload", 8'h28, 32'd10);
    idle(3);
    expect_rd("R4 between ticks", 8'h28, 32'd10);
    idle(1);
    expect_rd("R4 second tick", 8'h28, 32'd9);
    idle(4);
    expect_rd("R4 third tick", 8'h28, 32'd8);

    // R5 full range, R2 clock-source field stored
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0F);
    idle(1);
    expect_rd("R5 full range load", 8'h28, 32'hFFFF_FFFF);
    expect_rd("R2 source field readback", 8'h20, 32'h0D);
    idle(1);
    expect_rd("R5 full range step", 8'h28, 32'hFFFF_FFFE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule